// File: doc/BRIEF.md
# Dual Machine-Cycle Timer/Counter

This block holds two 8-bit-register timer/counter channels. Each channel keeps a low byte and a high byte and advances either once per machine cycle (timer function) or once per recognised falling edge on its own count input pin (counter function). A shared mode register picks, per channel, one of four counting arrangements: a 13-bit counter with a 5-bit prescale field, a 16-bit counter, an 8-bit counter with automatic reload, and a split arrangement in which channel 0 turns into two independent 8-bit counters while channel 1 halts.

Software reaches all state through a small register bus with combinational read data and single-cycle write strobes. Each channel may be gated by an external level input, raises a sticky overflow flag that is cleared by an acknowledge pulse or by a write, and can optionally flip a dedicated output pin on every overflow. A machine cycle lasts `CLKS_PER_MC` clocks (6 by default).

Top module: `dual_tmr_ctr`

## Requirements
- R1: In timer function a running channel advances by exactly one per machine cycle; any window of 6·N consecutive clock edges with the channel running yields exactly N advances.
- R2: In counter function the count pin is sampled once per machine cycle and the count advances by one when a sample of 1 is followed by a sample of 0; with each pin level held for at least two machine cycles every falling edge is counted exactly once.
- R3: A channel advances only while its run bit is 1 and either its gate bit is 0 or its gate pin is high; otherwise its count registers hold.
- R4: Register map on `bus_addr`: 0 mode, 1 control, 2 channel 0 low, 3 channel 0 high, 4 channel 1 low, 5 channel 1 high, 6 toggle enable in bits [1:0] (bit n for channel n), 7 reads zero. Mode bits: 7 gate1, 6 counter-select1, 5:4 mode1, 3 gate0, 2 counter-select0, 1:0 mode0 (counter-select 1 = count pin edges). Control bits: 7 flag1, 6 run1, 5 flag0, 4 run0, bits 3:0 read zero. After reset every register reads zero and all outputs are low.
- R5: Mode 0 counts through the low 5 bits of the low byte as a prescale field that carries into the 8-bit high byte; the upper 3 bits of the low byte keep whatever was written; overflow occurs when all 13 bits roll over to zero.
- R6: Mode 1 joins high and low bytes into one 16-bit counter; overflow occurs on the roll-over from FFFFh to 0000h.
- R7: Mode 2 counts in the low byte only; on roll-over from FFh the low byte takes the high byte's value and an overflow occurs.
- R8: With channel 0 in mode 3, its low byte counts under channel 0's run, gate and select bits and sets flag 0, its high byte counts machine cycles under run bit 1 alone and sets flag 1; channel 1 in mode 3 holds its count.
- R9: An overflow sets the channel's flag (`ovf_flag[n]`) at the same clock edge as the roll-over; a set takes priority over any clear in the same cycle.
- R10: A flag is cleared by a one-cycle `irq_ack[n]` pulse or by a control write of 0 to its bit; a control write of 1 sets it.
- R11: When toggle enable bit n is 1, `tgl_pin[n]` inverts on every event that sets flag n.
- R12: A bus write to a count byte takes priority over an advance in the same cycle, and setting a run bit leaves the count bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cnt_pin | input | 2 | Count input per channel (counter function) |
| gate_pin | input | 2 | Gate level input per channel |
| irq_ack | input | 2 | Flag acknowledge pulse per flag |
| ovf_flag | output | 2 | Overflow flags |
| tgl_pin | output | 2 | Overflow toggle outputs |

## Verification
A write commits at the rising edge during which `bus_wr` is high and reads back combinationally before the next edge; count bytes advance only at machine-cycle edges, so the bench starts and stops each run with bus writes whose committing edges are exactly 6·N edges apart, giving N advances whatever the prescaler phase. Flags and toggle outputs change at the roll-over edge itself, so they are sampled after the stopping write or, in split mode, one edge before it where the overflow is known to lie earlier. Counter-function edges are recognised at the first machine-cycle edge after the pin falls, so pin levels are held 12 clocks and margins of 12 clocks surround each pulse train. Write priority is checked by holding a write across six consecutive edges, one of which is a machine-cycle edge, and reading after each.

// File: rtl/tmrc_pkg.sv
package tmrc_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 3;

   typedef enum logic [1:0] {
      TM_PRESC  = 2'd0,
      TM_FULL   = 2'd1,
      TM_RELOAD = 2'd2,
      TM_SPLIT  = 2'd3
   } tm_mode_e;

   localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
   localparam logic [ADDR_W-1:0] A_LO0   = 3'd2;
   localparam logic [ADDR_W-1:0] A_HI0   = 3'd3;
   localparam logic [ADDR_W-1:0] A_LO1   = 3'd4;
   localparam logic [ADDR_W-1:0] A_HI1   = 3'd5;
   localparam logic [ADDR_W-1:0] A_TGLEN = 3'd6;
endpackage

// File: rtl/tmrc_mcycle.sv
module tmrc_mcycle #(
   parameter int CLKS_PER_MC = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MC - 1);

   generate
      if (CLKS_PER_MC < 2) begin : g_bad_len
         $error("CLKS_PER_MC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == LAST);

   // R1
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/tmrc_pinsamp.sv
module tmrc_pinsamp (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pin,
   output logic fall
);
   logic samp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    samp_q <= 1'b0;
      else if (tick) samp_q <= pin;
   end

   assign fall = tick & samp_q & ~pin;

   // R2
   fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !samp_q);
endmodule

// File: rtl/tmrc_channel.sv
module tmrc_channel
   import tmrc_pkg::*;
#(
   parameter int PRE_BITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tm_mode_e          mode,
   input  logic              step_lo,
   input  logic              step_hi,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] lo_q,
   output logic [BYTE_W-1:0] hi_q,
   output logic              ovf_lo,
   output logic              ovf_hi
);
   generate
      if (PRE_BITS < 1 || PRE_BITS >= BYTE_W) begin : g_bad_pre
         $error("PRE_BITS must lie between 1 and BYTE_W-1");
      end
   endgenerate

   logic [BYTE_W-1:0] lo_d, hi_d;

   always_comb begin
      lo_d   = lo_q;
      hi_d   = hi_q;
      ovf_lo = 1'b0;
      ovf_hi = 1'b0;
      case (mode)
         TM_PRESC: begin
            if (step_lo) begin
               if (&lo_q[PRE_BITS-1:0]) begin
                  lo_d[PRE_BITS-1:0] = '0;
                  hi_d   = hi_q + 1'b1;
                  ovf_lo = &hi_q;
               end else begin
                  lo_d[PRE_BITS-1:0] = lo_q[PRE_BITS-1:0] + 1'b1;
               end
            end
         end
         TM_FULL: begin
            if (step_lo) begin
               {hi_d, lo_d} = {hi_q, lo_q} + 1'b1;
               ovf_lo = &{hi_q, lo_q};
            end
         end
         TM_RELOAD: begin
            if (step_lo) begin
               if (&lo_q) begin
                  lo_d   = hi_q;
                  ovf_lo = 1'b1;
               end else begin
                  lo_d = lo_q + 1'b1;
               end
            end
         end
         default: begin
            if (step_lo) begin
               lo_d   = lo_q + 1'b1;
               ovf_lo = &lo_q;
            end
            if (step_hi) begin
               hi_d   = hi_q + 1'b1;
               ovf_hi = &hi_q;
            end
         end
      endcase
      if (wr_lo) lo_d = wdata;
      if (wr_hi) hi_d = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_d;
         hi_q <= hi_d;
      end
   end

   // R12
   wr_lo_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (lo_q == $past(wdata)));

   // R6
   full_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_FULL && step_lo && !wr_lo && !wr_hi)
      |=> ({hi_q, lo_q} == $past({hi_q, lo_q}) + 1'b1));

   // R7
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_RELOAD && step_lo && (&lo_q) && !wr_lo && !wr_hi)
      |=> (lo_q == $past(hi_q)));

   // R5
   presc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TM_PRESC && !wr_lo)
      |=> (lo_q[BYTE_W-1:PRE_BITS] == $past(lo_q[BYTE_W-1:PRE_BITS])));
endmodule

// File: rtl/dual_tmr_ctr.sv
module dual_tmr_ctr
   import tmrc_pkg::*;
#(
   parameter int CLKS_PER_MC = 6,
   parameter int PRE_BITS    = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic                   bus_wr,
   input  logic [BYTE_W-1:0]      bus_wdata,
   output logic [BYTE_W-1:0]      bus_rdata,
   input  logic [1:0]             cnt_pin,
   input  logic [1:0]             gate_pin,
   input  logic [1:0]             irq_ack,
   output logic [1:0]             ovf_flag,
   output logic [1:0]             tgl_pin
);
   localparam int NCH = 2;

   logic              tick;
   logic [BYTE_W-1:0] mode_q;
   logic [NCH-1:0]    run_q, tf_q, te_q, tgl_q;
   logic [NCH-1:0]    fall, step_lo, step_hi, wr_lo, wr_hi, ovf_lo, ovf_hi, ev;
   logic [BYTE_W-1:0] lo_q [NCH];
   logic [BYTE_W-1:0] hi_q [NCH];
   tm_mode_e          md   [NCH];
   logic              mode_wr, ctrl_wr, te_wr;

   assign mode_wr = bus_wr & (bus_addr == A_MODE);
   assign ctrl_wr = bus_wr & (bus_addr == A_CTRL);
   assign te_wr   = bus_wr & (bus_addr == A_TGLEN);

   tmrc_mcycle #(.CLKS_PER_MC(CLKS_PER_MC)) u_mcycle (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_ch
         logic gate_b, sel_b, allow, src;

         assign md[n]  = tm_mode_e'(mode_q[4*n+1 -: 2]);
         assign gate_b = mode_q[4*n+3];
         assign sel_b  = mode_q[4*n+2];
         assign allow  = run_q[n] & (~gate_b | gate_pin[n]);
         assign src    = sel_b ? fall[n] : tick;
         assign wr_lo[n] = bus_wr & (bus_addr == A_LO0 + ADDR_W'(2*n));
         assign wr_hi[n] = bus_wr & (bus_addr == A_HI0 + ADDR_W'(2*n));

         tmrc_pinsamp u_pinsamp (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .pin  (cnt_pin[n]),
            .fall (fall[n])
         );

         if (n == 0) begin : g_first
            assign step_lo[n] = allow & src;
            assign step_hi[n] = (md[0] == TM_SPLIT) & tick & run_q[1];
         end else begin : g_other
            assign step_lo[n] = allow & src & (md[n] != TM_SPLIT);
            assign step_hi[n] = 1'b0;
         end

         tmrc_channel #(.PRE_BITS(PRE_BITS)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (md[n]),
            .step_lo(step_lo[n]),
            .step_hi(step_hi[n]),
            .wr_lo  (wr_lo[n]),
            .wr_hi  (wr_hi[n]),
            .wdata  (bus_wdata),
            .lo_q   (lo_q[n]),
            .hi_q   (hi_q[n]),
            .ovf_lo (ovf_lo[n]),
            .ovf_hi (ovf_hi[n])
         );

         // R9
         flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev[n] |=> tf_q[n]);

         // R10
         ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack[n] && !ev[n] && !ctrl_wr) |=> !tf_q[n]);

         // R11
         tgl_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[n] && te_q[n]) |=> (tgl_q[n] != $past(tgl_q[n])));
      end
   endgenerate

   assign ev[0] = ovf_lo[0];
   assign ev[1] = ovf_lo[1] | ovf_hi[0] | ovf_hi[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         run_q  <= '0;
         te_q   <= '0;
      end else begin
         if (mode_wr) mode_q <= bus_wdata;
         if (ctrl_wr) run_q  <= {bus_wdata[6], bus_wdata[4]};
         if (te_wr)   te_q   <= bus_wdata[NCH-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tf_q  <= '0;
         tgl_q <= '0;
      end else begin
         for (int n = 0; n < NCH; n++) begin
            if (ev[n])           tf_q[n] <= 1'b1;
            else if (ctrl_wr)    tf_q[n] <= bus_wdata[5+2*n];
            else if (irq_ack[n]) tf_q[n] <= 1'b0;
            if (ev[n] && te_q[n]) tgl_q[n] <= ~tgl_q[n];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_MODE:  bus_rdata = mode_q;
         A_CTRL:  bus_rdata = {tf_q[1], run_q[1], tf_q[0], run_q[0], 4'b0000};
         A_LO0:   bus_rdata = lo_q[0];
         A_HI0:   bus_rdata = hi_q[0];
         A_LO1:   bus_rdata = lo_q[1];
         A_HI1:   bus_rdata = hi_q[1];
         A_TGLEN: bus_rdata[NCH-1:0] = te_q;
         default: bus_rdata = '0;
      endcase
   end

   assign ovf_flag = tf_q;
   assign tgl_pin  = tgl_q;

   // R8
   split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (md[1] == TM_SPLIT && !wr_lo[1] && !wr_hi[1])
      |=> ($stable(lo_q[1]) && $stable(hi_q[1])));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[0] && md[0] != TM_SPLIT && !wr_lo[0] && !wr_hi[0])
      |=> ($stable(lo_q[0]) && $stable(hi_q[0])));
endmodule

// File: tb/dual_tmr_ctr_tb.sv
`timescale 1ns/1ps
module dual_tmr_ctr_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] cnt_pin = '0;
   logic [1:0] gate_pin = '0;
   logic [1:0] irq_ack = '0;
   logic [1:0] ovf_flag;
   logic [1:0] tgl_pin;

   int checks = 0;
   int errors = 0;

   localparam logic [2:0] MODE = 3'd0, CTRL = 3'd1, LO0 = 3'd2, HI0 = 3'd3,
                          LO1 = 3'd4, HI1 = 3'd5, TGLEN = 3'd6, SPARE = 3'd7;

   // {ch, mode, lo, hi, machine cycles, exp lo, exp hi, exp flag}
   localparam logic [43:0] VEC [9] = '{
      {1'b0, 2'd1, 8'hFE, 8'h12, 8'd3,  8'h01, 8'h13, 1'b0},
      {1'b0, 2'd1, 8'hFE, 8'hFF, 8'd3,  8'h01, 8'h00, 1'b1},
      {1'b0, 2'd0, 8'hFE, 8'h05, 8'd3,  8'hE1, 8'h06, 1'b0},
      {1'b0, 2'd0, 8'h1F, 8'hFF, 8'd2,  8'h01, 8'h00, 1'b1},
      {1'b0, 2'd2, 8'hFE, 8'h80, 8'd4,  8'h82, 8'h80, 1'b1},
      {1'b0, 2'd2, 8'h10, 8'h80, 8'd5,  8'h15, 8'h80, 1'b0},
      {1'b1, 2'd1, 8'hF0, 8'h00, 8'd20, 8'h04, 8'h01, 1'b0},
      {1'b1, 2'd2, 8'hFD, 8'hF0, 8'd5,  8'hF2, 8'hF0, 1'b1},
      {1'b1, 2'd0, 8'h00, 8'h00, 8'd40, 8'h08, 8'h01, 1'b0}
   };

   dual_tmr_ctr u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_pin(cnt_pin),
      .gate_pin(gate_pin), .irq_ack(irq_ack), .ovf_flag(ovf_flag), .tgl_pin(tgl_pin)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // called at a falling edge; commits at the next rising edge
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // start and stop commits exactly 6*n edges apart: n machine cycles
   task automatic window(input logic [7:0] start_ctrl, input int n,
                         input logic [2:0] stop_a, input logic [7:0] stop_d);
      wr(CTRL, start_ctrl);
      repeat (6*n - 1) @(negedge clk);
      wr(stop_a, stop_d);
   endtask

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), r);
         chk("R4 reset register", r, 8'h00);
      end
      chk("R4 reset flags", {6'b0, ovf_flag}, 8'h00);
      chk("R4 reset toggles", {6'b0, tgl_pin}, 8'h00);

      // R1 R5 R6 R7 R9 R12: vector table, counts start from written values
      for (int i = 0; i < 9; i++) begin
         logic [43:0] v;
         logic [7:0]  mv;
         logic [2:0]  la;
         v  = VEC[i];
         mv = v[43] ? {2'b00, v[42:41], 4'b0000} : {6'b0, v[42:41]};
         la = v[43] ? LO1 : LO0;
         wr(CTRL, 8'h00);
         wr(MODE, mv);
         wr(la, v[40:33]);
         wr(la + 3'd1, v[32:25]);
         window(v[43] ? 8'h40 : 8'h10, int'(v[24:17]), MODE, mv | (v[43] ? 8'h80 : 8'h08));
         rd(la, r);
         chk($sformatf("R1/R5-R7 vector %0d low byte", i), r, v[16:9]);
         rd(la + 3'd1, r);
         chk($sformatf("R1/R5-R7 vector %0d high byte", i), r, v[8:1]);
         chk($sformatf("R9 vector %0d flag", i), {7'b0, ovf_flag[v[43]]}, {7'b0, v[0]});
      end

      // R10 software set, acknowledge, software clear
      wr(CTRL, 8'hA0);
      chk("R10 software set flags", {6'b0, ovf_flag}, 8'h03);
      rd(CTRL, r);
      chk("R4 control readback", r, 8'hA0);
      irq_ack = 2'b01;
      @(negedge clk);
      irq_ack = 2'b00;
      chk("R10 ack clears flag 0 only", {6'b0, ovf_flag}, 8'h02);
      wr(CTRL, 8'h00);
      chk("R10 software clear", {6'b0, ovf_flag}, 8'h00);

      // R12 write held across six edges, one of them a machine-cycle edge
      wr(MODE, 8'h01);
      wr(LO0, 8'h00);
      wr(HI0, 8'h00);
      wr(CTRL, 8'h10);
      begin
         logic ok;
         ok = 1'b1;
         bus_addr = LO0; bus_wdata = 8'h40; bus_wr = 1'b1;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            #1;
            if (bus_rdata !== 8'h40) ok = 1'b0;
         end
         bus_wr = 1'b0;
         chk("R12 write beats advance", {7'b0, ok}, 8'h01);
      end
      wr(CTRL, 8'h00);

      // R3 gating
      wr(MODE, 8'h09);
      wr(LO0, 8'h00);
      gate_pin = 2'b00;
      window(8'h10, 4, CTRL, 8'h00);
      rd(LO0, r);
      chk("R3 gate pin low blocks", r, 8'h00);
      gate_pin = 2'b01;
      window(8'h10, 4, CTRL, 8'h00);
      rd(LO0, r);
      chk("R3 gate pin high counts", r, 8'h04);
      repeat (30) @(negedge clk);
      rd(LO0, r);
      chk("R3 run bit off holds", r, 8'h04);
      gate_pin = 2'b00;

      // R2 counter function on channel 1
      wr(MODE, 8'h50);
      wr(LO1, 8'h00);
      wr(HI1, 8'h00);
      cnt_pin[1] = 1'b1;
      wr(CTRL, 8'h40);
      repeat (12) @(negedge clk);
      for (int p = 0; p < 5; p++) begin
         cnt_pin[1] = 1'b0;
         repeat (12) @(negedge clk);
         cnt_pin[1] = 1'b1;
         repeat (12) @(negedge clk);
      end
      repeat (12) @(negedge clk);
      wr(CTRL, 8'h00);
      rd(LO1, r);
      chk("R2 five falling edges", r, 8'h05);
      rd(HI1, r);
      chk("R2 high byte", r, 8'h00);

      // R8 split mode
      wr(MODE, 8'h33);
      wr(LO0, 8'hF0);
      wr(HI0, 8'hFE);
      wr(LO1, 8'h11);
      wr(HI1, 8'h22);
      wr(CTRL, 8'h50);
      repeat (17) @(negedge clk);
      chk("R8 split high byte sets flag 1", {6'b0, ovf_flag}, 8'h02);
      wr(CTRL, 8'h00);
      rd(LO0, r);
      chk("R8 split low byte", r, 8'hF3);
      rd(HI0, r);
      chk("R8 split high byte", r, 8'h01);
      rd(LO1, r);
      chk("R8 channel 1 stopped low", r, 8'h11);
      rd(HI1, r);
      chk("R8 channel 1 stopped high", r, 8'h22);

      // R11 toggle on overflow
      wr(TGLEN, 8'h01);
      wr(MODE, 8'h02);
      wr(LO0, 8'hFE);
      wr(HI0, 8'hFE);
      window(8'h10, 3, CTRL, 8'h00);
      rd(LO0, r);
      chk("R7 reload then advance", r, 8'hFF);
      chk("R11 toggle after one overflow", {6'b0, tgl_pin}, 8'h01);
      rd(TGLEN, r);
      chk("R4 toggle enable readback", r, 8'h01);

      // R4 spare address and control low nibble
      wr(CTRL, 8'h0F);
      rd(CTRL, r);
      chk("R4 control low bits read zero", r, 8'h00);
      rd(SPARE, r);
      chk("R4 spare address reads zero", r, 8'h00);
      rd(MODE, r);
      chk("R4 mode readback", r, 8'h02);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule